// File: doc/BRIEF.md
# MII Nibble Transmit Framer

This block sits on the MAC side of a media-independent interface and turns a byte stream into the nibble stream a PHY expects on its transmit pins. It runs entirely on the PHY-supplied transmit clock. When the byte source offers a frame, the framer first sends a preamble and start delimiter that it generates itself. It then sends the payload bytes, low nibble first, and holds the transmit enable high for exactly the nibbles of that frame. After each frame it keeps the line quiet for a parameterised number of clocks before it starts the next preamble.

A mode pin picks a one-bit serial variant. In that mode only data bit 0 carries the stream, least significant bit first, and the upper three data bits stay at zero. The pin is sampled when a frame starts, so each frame goes out whole in a single mode.

The byte source uses a valid/ready handshake, and a byte moves on a clock edge where both are high. Once the source raises valid, it must hold valid, data and last steady until that byte is accepted. The framer raises ready only in the final nibble (or bit) slot of the byte on the line, so the handshake throttles the source to the line rate. If valid is low in a slot where ready is high, the frame is cut short after the bytes already sent, and a sticky underrun flag is set.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is held and right after it, tx_en, txd, s_ready and underrun are all 0.
- R2: A frame starts when s_valid is high while the framer is idle. tx_en rises with the first preamble nibble. The preamble is seven bytes of 0x55 followed by 0xD5, each byte sent low nibble first (bits 3:0, then 7:4).
- R3: While tx_en is low, txd is 4'b0000.
- R4: In serial mode (serial_mode = 1 at frame start), each byte goes out on txd[0] one bit per clock, bit 0 first, and txd[3:1] stay 0.
- R5: s_ready is high only while tx_en is high, never on two consecutive clocks, and once per byte slot: every 2 clocks in nibble mode and every 8 in serial mode. It is high exactly once per payload byte requested.
- R6: Accepted payload bytes go out in order after the start delimiter. The frame ends with the final slot of the byte that carried s_last. tx_en is high for exactly (8+N)×2 clocks in nibble mode, or (8+N)×8 in serial mode, for N payload bytes, with no trailing enable cycle.
- R7: Between two frames tx_en stays low for at least GAP_CLKS clocks. If the next frame is already offered, the gap is exactly GAP_CLKS clocks.
- R8: If s_valid is low while s_ready is high, the frame ends after the last accepted byte. underrun then goes to 1 and stays at 1 until reset, including across later good frames.
- R9: A change of serial_mode during a frame has no effect on that frame. The new value applies from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock supplied by the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_mode | input | 1 | 1 selects one-bit serial output on txd[0]; sampled at frame start |
| s_valid | input | 1 | Source offers a byte |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Offered byte is the last one of the frame |
| s_ready | output | 1 | Framer accepts the offered byte on this edge |
| tx_en | output | 1 | Transmit enable, high for every nibble of a frame |
| txd | output | 4 | Transmit data nibble (only bit 0 used in serial mode) |
| underrun | output | 1 | Sticky flag: a frame was truncated by a missing byte |

## Verification
A frame offered to an idle framer raises tx_en on the clock edge that samples s_valid. A byte accepted at the edge that ends the previous slot appears on txd in the very next cycle. tx_en falls on the edge after the final slot, and the next preamble begins GAP_CLKS edges later when a frame is waiting. The bench drives inputs just after the falling edge and samples outputs on the falling edge, so each nibble is read in the middle of the cycle in which it is valid. Frame contents, enable length, ready count and gap length are compared against values computed from the requirements once tx_en falls.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NIB_W    = 4;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
endpackage

// File: rtl/mii_tx_gap_timer.sv
module mii_tx_gap_timer #(
  parameter int unsigned GAP_CLKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int unsigned CW = $clog2(GAP_CLKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(GAP_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mii_tx_shift.sv
module mii_tx_shift
  import mii_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial,
  input  logic              active,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              slot_last,
  output logic [NIB_W-1:0]  txd
);
  logic [BYTE_W-1:0] byte_q;
  logic [2:0]        pos_q;
  logic [NIB_W-1:0]  nib_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      pos_q  <= '0;
    end else if (load) begin
      byte_q <= load_byte;
      pos_q  <= '0;
    end else if (active) begin
      pos_q  <= pos_q + 3'd1;
    end
  end

  assign slot_last = serial ? (pos_q == 3'd7) : (pos_q[0] == 1'b1);

  always_comb begin
    if (serial)         nib_sel = {3'b000, byte_q[pos_q]};
    else if (pos_q[0])  nib_sel = byte_q[7:4];
    else                nib_sel = byte_q[3:0];
  end

  assign txd = active ? nib_sel : '0;
endmodule

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
#(
  parameter int unsigned PRE_BYTES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_mode,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              slot_last,
  input  logic              gap_expired,
  output logic              active,
  output logic              mode_q,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic              gap_start,
  output logic              underrun
);
  localparam int unsigned PW = $clog2(PRE_BYTES + 1);
  localparam logic [PW-1:0] PRE_END = PW'(PRE_BYTES);

  tx_state_e     state_q, state_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          last_q, last_d;
  logic          mode_d;
  logic          urun_d;
  logic          slot_end;
  logic          start_ok;

  assign active   = (state_q == ST_PRE) || (state_q == ST_DATA);
  assign slot_end = active && slot_last;
  assign start_ok = (state_q == ST_IDLE) || ((state_q == ST_GAP) && gap_expired);
  assign s_ready  = slot_end &&
                    (((state_q == ST_PRE) && (pre_q == PRE_END)) ||
                     ((state_q == ST_DATA) && !last_q));

  always_comb begin
    state_d   = state_q;
    pre_d     = pre_q;
    last_d    = last_q;
    mode_d    = mode_q;
    urun_d    = underrun;
    load      = 1'b0;
    load_byte = PRE_BYTE;
    gap_start = 1'b0;
    if (start_ok) begin
      if (s_valid) begin
        state_d = ST_PRE;
        pre_d   = '0;
        mode_d  = serial_mode;
        load    = 1'b1;
      end else begin
        state_d = ST_IDLE;
      end
    end else if (slot_end) begin
      if ((state_q == ST_PRE) && (pre_q != PRE_END)) begin
        pre_d     = pre_q + 1'b1;
        load      = 1'b1;
        load_byte = (pre_q == PRE_END - 1'b1) ? SFD_BYTE : PRE_BYTE;
      end else if ((state_q == ST_DATA) && last_q) begin
        state_d   = ST_GAP;
        gap_start = 1'b1;
      end else if (s_valid) begin
        state_d   = ST_DATA;
        last_d    = s_last;
        load      = 1'b1;
        load_byte = s_data;
      end else begin
        state_d   = ST_GAP;
        gap_start = 1'b1;
        urun_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pre_q    <= '0;
      last_q   <= 1'b0;
      mode_q   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      state_q  <= state_d;
      pre_q    <= pre_d;
      last_q   <= last_d;
      mode_q   <= mode_d;
      underrun <= urun_d;
    end
  end
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_tx_pkg::*;
#(
  parameter int unsigned GAP_CLKS  = 24,
  parameter int unsigned PRE_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_mode,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       tx_en,
  output logic [3:0] txd,
  output logic       underrun
);
  logic              slot_last;
  logic              gap_expired;
  logic              mode_q;
  logic              load;
  logic [BYTE_W-1:0] load_byte;
  logic              gap_start;

  mii_tx_ctrl #(.PRE_BYTES(PRE_BYTES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .serial_mode (serial_mode),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .s_last      (s_last),
    .s_ready     (s_ready),
    .slot_last   (slot_last),
    .gap_expired (gap_expired),
    .active      (tx_en),
    .mode_q      (mode_q),
    .load        (load),
    .load_byte   (load_byte),
    .gap_start   (gap_start),
    .underrun    (underrun)
  );

  mii_tx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .serial    (mode_q),
    .active    (tx_en),
    .load      (load),
    .load_byte (load_byte),
    .slot_last (slot_last),
    .txd       (txd)
  );

  mii_tx_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (gap_start),
    .expired (gap_expired)
  );
endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk #(
  parameter int unsigned GAP_CLKS = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic [3:0] txd,
  input logic       s_ready,
  input logic       underrun,
  input logic       mode_q
);
  localparam int unsigned LW = $clog2(GAP_CLKS + 1);

  logic [LW-1:0] low_cnt;
  logic          prev_en;
  logic          seen_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      prev_en  <= 1'b0;
      seen_end <= 1'b0;
    end else begin
      prev_en <= tx_en;
      if (tx_en)                        low_cnt <= '0;
      else if (low_cnt < LW'(GAP_CLKS)) low_cnt <= low_cnt + 1'b1;
      if (prev_en && !tx_en)            seen_end <= 1'b1;
    end
  end

  a_r3_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == 4'b0000));

  a_r4_serial_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && mode_q) |-> (txd[3:1] == 3'b000));

  a_r5_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> tx_en);

  a_r5_ready_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !prev_en && seen_end) |-> (low_cnt >= LW'(GAP_CLKS)));

  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && prev_en) |-> $stable(mode_q));
endmodule

bind mii_tx_framer mii_tx_framer_chk #(.GAP_CLKS(GAP_CLKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .txd      (txd),
  .s_ready  (s_ready),
  .underrun (underrun),
  .mode_q   (mode_q)
);

// File: tb/sim_mii_tx_framer.sv
module sim_mii_tx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 24;
  localparam int MAXB       = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serial_mode = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       s_ready, tx_en, underrun;
  logic [3:0] txd;

  mii_tx_framer #(.GAP_CLKS(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .tx_en(tx_en),
    .txd(txd), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_run = 0, n_fail = 0;
  logic [7:0] pay [0:1][0:MAXB-1];
  logic [7:0] rx  [0:MAXB+15];
  int   rx_n, bitpos, en_cyc, rdy_cnt, low_run, gap_before;
  int   frames_done = 0, idle_viol = 0, upper_viol = 0;
  logic [7:0] acc;
  logic prev_en = 1'b0, seen_end = 1'b0, frame_mode = 1'b0;
  int   cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // Monitor: samples on the falling edge, mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (!prev_en) begin
          rx_n = 0; bitpos = 0; en_cyc = 0; rdy_cnt = 0; acc = 8'h00;
          gap_before = seen_end ? low_run : -1;
        end
        en_cyc++;
        if (s_ready) rdy_cnt++;
        if (frame_mode) begin
          if (txd[3:1] != 3'b000) upper_viol++;
          acc[bitpos] = txd[0];
          bitpos += 1;
        end else begin
          acc[bitpos +: 4] = txd;
          bitpos += 4;
        end
        if (bitpos == 8) begin
          if (rx_n < MAXB + 16) rx[rx_n] = acc;
          rx_n++;
          bitpos = 0;
        end
        low_run = 0;
      end else begin
        if (txd != 4'b0000) idle_viol++;
        if (s_ready) idle_viol++;
        low_run++;
        if (prev_en) begin
          seen_end = 1'b1;
          frames_done++;
        end
      end
      prev_en = tx_en;
    end
  end

  function automatic logic [7:0] exp_byte(input int slot, input int i);
    if (i < 7)  return 8'h55;
    if (i == 7) return 8'hD5;
    return pay[slot][i-8];
  endfunction

  task automatic check_frame(input int slot, input int n, input bit mode,
                             input bit cut, input int exp_gap);
    int bad = 0;
    int first_bad = -1;
    chk(rx_n == 8 + n, "R6 byte count", rx_n, 8 + n);
    for (int i = 0; i < 8 && i < rx_n; i++)
      if (rx[i] != exp_byte(slot, i)) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, "R2 preamble/SFD", first_bad, -1);
    bad = 0; first_bad = -1;
    for (int i = 8; i < rx_n && i < 8 + n; i++)
      if (rx[i] != exp_byte(slot, i)) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, mode ? "R4 serial payload" : "R6 payload", first_bad, -1);
    chk(bitpos == 0, "R6 no partial byte", bitpos, 0);
    chk(en_cyc == (8 + n) * (mode ? 8 : 2), "R6 tx_en length", en_cyc, (8 + n) * (mode ? 8 : 2));
    chk(rdy_cnt == n + (cut ? 1 : 0), "R5 ready pulses", rdy_cnt, n + (cut ? 1 : 0));
    chk(idle_viol == 0, "R3 idle txd zero", idle_viol, 0);
    if (mode) chk(upper_viol == 0, "R4 upper bits zero", upper_viol, 0);
    if (gap_before >= 0) chk(gap_before >= GAP, "R7 min gap", gap_before, GAP);
    if (exp_gap >= 0) chk(gap_before == exp_gap, "R7 exact gap", gap_before, exp_gap);
    if (cut) chk(underrun == 1'b1, "R8 underrun set", underrun, 1);
  endtask

  // Offer bytes of pay[slot]; stop after byte 'cut' if cut >= 0.
  task automatic send(input int slot, input int n, input int cut, input int flip_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = pay[slot][i]; s_last = (cut < 0) && (i == n - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1;
      if (i == flip_at) serial_mode = ~serial_mode;
      if (i == cut) begin s_valid = 1'b0; s_last = 1'b0; return; end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic fill(input int slot, input int n);
    for (int i = 0; i < n; i++) pay[slot][i] = 8'($urandom);
  endtask

  task automatic one_frame(input int n, input bit mode, input int cut, input int flip_at);
    int base;
    int nexp;
    base = frames_done;
    fill(0, n);
    serial_mode = mode;
    frame_mode  = mode;
    send(0, n, cut, flip_at);
    wait (frames_done == base + 1);
    nexp = (cut >= 0) ? cut + 1 : n;
    check_frame(0, nexp, mode, cut >= 0, -1);
    serial_mode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int base;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_en == 1'b0, "R1 tx_en reset", tx_en, 0);
    chk(txd == 4'b0000, "R1 txd reset", txd, 0);
    chk(s_ready == 1'b0, "R1 s_ready reset", s_ready, 0);
    chk(underrun == 1'b0, "R1 underrun reset", underrun, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_en == 1'b0 && underrun == 1'b0, "R1 after reset", tx_en, 0);

    // Directed: single-byte frames in both modes (R2, R4, R6)
    one_frame(1, 1'b0, -1, -1);
    one_frame(1, 1'b1, -1, -1);

    // Directed: back-to-back frames, exact gap (R7)
    frame_mode = 1'b0; serial_mode = 1'b0;
    fill(0, 3); fill(1, 2);
    base = frames_done;
    fork
      begin send(0, 3, -1, -1); send(1, 2, -1, -1); end
      begin
        wait (frames_done == base + 1);
        check_frame(0, 3, 1'b0, 1'b0, -1);
        wait (frames_done == base + 2);
        check_frame(1, 2, 1'b0, 1'b0, GAP);
      end
    join
    chk(underrun == 1'b0, "R8 no underrun on good frames", underrun, 0);

    // Directed: mode pin flipped mid-frame has no effect (R9)
    one_frame(4, 1'b1, -1, 1);
    one_frame(4, 1'b0, -1, 0);

    // Directed: underrun truncation (R8), then stickiness across a good frame
    one_frame(6, 1'b0, 2, -1);
    one_frame(3, 1'b1, -1, -1);
    chk(underrun == 1'b1, "R8 underrun sticky", underrun, 1);

    // Random frames
    for (int k = 0; k < 16; k++) begin
      int n;
      bit m;
      n = 1 + int'($urandom % 12);
      m = 1'($urandom);
      repeat (int'($urandom % 5)) @(negedge clk);
      one_frame(n, m, -1, -1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule